// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core with Traps

This block is a 32-bit processor core that runs each instruction over several clock cycles. A single adder/logic unit and a single memory port serve every step of an instruction. A Moore state machine picks, cycle by cycle, what the unit computes and which address the memory sees. The core executes word loads and stores, five register-to-register operations (add, subtract, and, or, signed set-less-than), a branch-if-equal and an absolute jump.

Two events divert the flow to a fixed handler address. The first is signed overflow on add or subtract. The second is an instruction whose opcode or function code is not in the set. In both cases the core records the address of the faulting instruction and a reason code before it jumps. The surrounding system supplies a memory with one synchronous port: read data appears in the cycle after the address. It reads `pc_o`, `epc_o` and `cause_o` to follow control flow and trap state.

Top module: `mc_core`

## Requirements
- R1: While `rst_ni` is low, PC, EPC and Cause read zero and `mem_we_o` is low. After release the first cycle is an instruction fetch at address 0.
- R2: A fetch presents PC on `mem_addr_o` and advances PC by 4 at the end of that cycle. Memory is addressed in 32-bit words: the two low address bits are ignored by the memory, and read data arrives one cycle after its address.
- R3: Instruction lengths in cycles are: register-register 4, load 5, store 4, branch 3, jump 3.
- R4: Opcode 0 selects a register-register operation on rs (bits 25:21) and rt (bits 20:16), with the result written to rd (bits 15:11). The function codes (bits 5:0) are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R5: A load (opcode 0x23) writes the word at rs + sign-extended bits 15:0 into rt. A store (opcode 0x2B) writes rt to that address.
- R6: A branch (opcode 0x04) sets PC to (address + 4) + (sign-extended bits 15:0 × 4) when rs equals rt, and otherwise falls through to the next instruction.
- R7: A jump (opcode 0x02) sets PC to the top four bits of the incremented PC followed by bits 25:0 × 4.
- R8: Register 0 reads as zero; writes to it have no effect.
- R9: When add or subtract overflows as signed, rd is not written. Cause becomes 1, EPC becomes the instruction's address and PC becomes 0xC0000000 in the fifth cycle of that instruction.
- R10: An opcode outside R4–R7, or opcode 0 with a function code outside R4, sets Cause to 0, EPC to the instruction's address and PC to 0xC0000000 in the third cycle.
- R11: PC changes only on fetch, branch, jump or trap. EPC and Cause change only on a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Byte address to memory, for both reads and writes |
| mem_we_o | output | 1 | Write strobe for the addressed word |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data for the address presented in the previous cycle |
| pc_o | output | 32 | Current program counter |
| epc_o | output | 32 | Address of the last trapping instruction |
| cause_o | output | 32 | Trap reason: 1 overflow, 0 undefined instruction |

## Verification
The assertions assume that `mem_rdata_i` holds, in every cycle, the word at the address presented one cycle earlier. The decode step and the load write-back read it directly and do not re-register it. They also assume that reset is held for at least one clock edge, so the state machine starts in fetch. The bench's memory model is a word array clocked on the same edge, so the latency always holds. Programs are loaded only while reset is held, and every sampling point is counted from the reset release in whole clock edges.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int          XLEN     = 32;
  localparam int          NREG     = 32;
  localparam int          RIDX_W   = $clog2(NREG);
  localparam logic [31:0] RESET_PC = 32'h0000_0000;
  localparam logic [31:0] TRAP_VEC = 32'hC000_0000;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_LDWB, S_MEMWR,
    S_REXEC, S_RWB, S_BRANCH, S_JUMP, S_TRAP
  } state_e;

  typedef enum logic       {SRCA_PC, SRCA_REG} srca_e;
  typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMMSH} srcb_e;
  typedef enum logic [1:0] {PCS_ALU, PCS_ALUOUT, PCS_JUMP, PCS_VEC} pcsrc_e;

  typedef struct packed {
    alu_op_e alu_op;
    srca_e   src_a;
    srcb_e   src_b;
    logic    pc_we;
    pcsrc_e  pc_src;
    logic    ir_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mem;
    logic    addr_from_alu;
    logic    mem_we;
    logic    trap_we;
    logic    cause_val;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o,
  output logic         ovf_o
);
  logic         sub;
  logic [W-1:0] b_eff, sum;
  logic         ovf_raw;

  assign sub     = (op_i == ALU_SUB) || (op_i == ALU_SLT);
  assign b_eff   = sub ? ~b_i : b_i;
  assign sum     = a_i + b_eff + {{(W-1){1'b0}}, sub};
  assign ovf_raw = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

  always_comb begin
    unique case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, sum[W-1] ^ ovf_raw};
      default: y_o = sum;
    endcase
  end

  assign zero_o = (y_o == '0);
  assign ovf_o  = ovf_raw && ((op_i == ALU_ADD) || (op_i == ALU_SUB));
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile
  import mc_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs[ra2_i];
endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] dec_op_i,
  input  logic [5:0] dec_fn_i,
  input  logic [5:0] ir_op_i,
  input  logic [5:0] ir_fn_i,
  input  logic       alu_zero_i,
  input  logic       ovf_q_i,
  output ctrl_t      ctrl_o,
  output state_e     state_o
);
  state_e state_q, state_d;

  function automatic logic is_legal(logic [5:0] op, logic [5:0] fn);
    unique case (op)
      OP_RTYPE: return fn inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT};
      OP_LW, OP_SW, OP_BEQ, OP_J: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic alu_op_e rop(logic [5:0] fn);
    unique case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        if (!is_legal(dec_op_i, dec_fn_i))            state_d = S_TRAP;
        else if (dec_op_i inside {OP_LW, OP_SW})      state_d = S_MEMADR;
        else if (dec_op_i == OP_BEQ)                  state_d = S_BRANCH;
        else if (dec_op_i == OP_J)                    state_d = S_JUMP;
        else                                          state_d = S_REXEC;
      end
      S_MEMADR: state_d = (ir_op_i == OP_LW) ? S_MEMRD : S_MEMWR;
      S_MEMRD:  state_d = S_LDWB;
      S_REXEC:  state_d = S_RWB;
      S_RWB:    state_d = ovf_q_i ? S_TRAP : S_FETCH;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    ctrl_o.src_a  = SRCA_PC;
    ctrl_o.src_b  = SRCB_FOUR;
    ctrl_o.pc_src = PCS_ALU;
    unique case (state_q)
      S_FETCH:  ctrl_o.pc_we = 1'b1;
      S_DECODE: begin
        ctrl_o.ir_we = 1'b1;
        ctrl_o.src_b = SRCB_IMMSH;  // speculative branch target
      end
      S_MEMADR: begin
        ctrl_o.src_a = SRCA_REG;
        ctrl_o.src_b = SRCB_IMM;
      end
      S_MEMRD:  ctrl_o.addr_from_alu = 1'b1;
      S_LDWB: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.rf_from_mem = 1'b1;
      end
      S_MEMWR: begin
        ctrl_o.addr_from_alu = 1'b1;
        ctrl_o.mem_we        = 1'b1;
      end
      S_REXEC: begin
        ctrl_o.src_a  = SRCA_REG;
        ctrl_o.src_b  = SRCB_REG;
        ctrl_o.alu_op = rop(ir_fn_i);
      end
      S_RWB: begin
        ctrl_o.rf_we     = !ovf_q_i;
        ctrl_o.rf_dst_rd = 1'b1;
      end
      S_BRANCH: begin
        ctrl_o.src_a  = SRCA_REG;
        ctrl_o.src_b  = SRCB_REG;
        ctrl_o.alu_op = ALU_SUB;
        ctrl_o.pc_we  = alu_zero_i;
        ctrl_o.pc_src = PCS_ALUOUT;
      end
      S_JUMP: begin
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pc_src = PCS_JUMP;
      end
      S_TRAP: begin
        ctrl_o.alu_op    = ALU_SUB;  // PC - 4 -> EPC
        ctrl_o.pc_we     = 1'b1;
        ctrl_o.pc_src    = PCS_VEC;
        ctrl_o.trap_we   = 1'b1;
        ctrl_o.cause_val = is_legal(ir_op_i, ir_fn_i);
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  // R3
  fetch_to_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH) |=> (state_q == S_DECODE));

  // R9
  ovf_goes_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RWB && ovf_q_i) |=> (state_q == S_TRAP));
endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core
  import mc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] mem_addr_o,
  output logic        mem_we_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic [31:0] pc_o,
  output logic [31:0] epc_o,
  output logic [31:0] cause_o
);
  ctrl_t  ctrl;
  state_e state;

  logic [XLEN-1:0]   pc_q, ir_q, epc_q, cause_q;
  logic [XLEN-1:0]   a_q, b_q, aluout_q;
  logic              ovf_q;
  logic [XLEN-1:0]   rd1, rd2, alu_a, alu_b, alu_y, imm_sx, pc_d;
  logic              alu_zero, alu_ovf;
  logic [RIDX_W-1:0] ra1, ra2, wa;
  logic [15:0]       imm16;

  // during decode the instruction is taken from the read port, IR loads at its end
  assign ra1    = ctrl.ir_we ? mem_rdata_i[25:21] : ir_q[25:21];
  assign ra2    = ctrl.ir_we ? mem_rdata_i[20:16] : ir_q[20:16];
  assign imm16  = ctrl.ir_we ? mem_rdata_i[15:0]  : ir_q[15:0];
  assign imm_sx = {{(XLEN-16){imm16[15]}}, imm16};
  assign wa     = ctrl.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];

  mc_regfile u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (ra1),
    .ra2_i (ra2),
    .rd1_o (rd1),
    .rd2_o (rd2),
    .we_i  (ctrl.rf_we),
    .wa_i  (wa),
    .wd_i  (ctrl.rf_from_mem ? mem_rdata_i : aluout_q)
  );

  assign alu_a = (ctrl.src_a == SRCA_PC) ? pc_q : a_q;
  always_comb begin
    unique case (ctrl.src_b)
      SRCB_REG:   alu_b = b_q;
      SRCB_FOUR:  alu_b = 32'd4;
      SRCB_IMM:   alu_b = imm_sx;
      default:    alu_b = {imm_sx[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu u_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .op_i  (ctrl.alu_op),
    .y_o   (alu_y),
    .zero_o(alu_zero),
    .ovf_o (alu_ovf)
  );

  mc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_op_i  (mem_rdata_i[31:26]),
    .dec_fn_i  (mem_rdata_i[5:0]),
    .ir_op_i   (ir_q[31:26]),
    .ir_fn_i   (ir_q[5:0]),
    .alu_zero_i(alu_zero),
    .ovf_q_i   (ovf_q),
    .ctrl_o    (ctrl),
    .state_o   (state)
  );

  always_comb begin
    unique case (ctrl.pc_src)
      PCS_ALU:    pc_d = alu_y;
      PCS_ALUOUT: pc_d = aluout_q;
      PCS_JUMP:   pc_d = {pc_q[31:28], ir_q[25:0], 2'b00};
      default:    pc_d = TRAP_VEC;
    endcase
  end

  // short-lived values: no enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      a_q      <= rd1;
      b_q      <= rd2;
      aluout_q <= alu_y;
      ovf_q    <= alu_ovf;
    end
  end

  // long-lived values: explicit enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      if (ctrl.pc_we)   pc_q    <= pc_d;
      if (ctrl.ir_we)   ir_q    <= mem_rdata_i;
      if (ctrl.trap_we) epc_q   <= alu_y;
      if (ctrl.trap_we) cause_q <= {{(XLEN-1){1'b0}}, ctrl.cause_val};
    end
  end

  assign mem_addr_o  = ctrl.addr_from_alu ? aluout_q : pc_q;
  assign mem_we_o    = ctrl.mem_we;
  assign mem_wdata_o = b_q;
  assign pc_o        = pc_q;
  assign epc_o       = epc_q;
  assign cause_o     = cause_q;

  // R2
  fetch_pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));

  // R10
  trap_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_TRAP) |=> (pc_q == TRAP_VEC));

  // R9
  trap_epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_TRAP) |=> (epc_q == $past(pc_q) - 32'd4));

  // R11
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {S_DECODE, S_MEMADR, S_MEMRD, S_LDWB, S_MEMWR, S_REXEC, S_RWB})
    |=> $stable(pc_q));

  // R11
  epc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != S_TRAP) |=> ($stable(epc_q) && $stable(cause_q)));
endmodule

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc, epc, cause;
  logic        mem_we;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mc_core u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr),
    .mem_we_o   (mem_we),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .pc_o       (pc),
    .epc_o      (epc),
    .cause_o    (cause)
  );

  // word memory: low region 0..127, trap-vector region 128..255
  logic [31:0] mem [256];
  logic        clr = 1'b0, ld_en = 1'b0;
  logic [7:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;

  function automatic logic [7:0] widx(logic [31:0] a);
    return {a[31], a[8:2]};
  endfunction

  always @(posedge clk_i) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (ld_en) mem[ld_idx] <= ld_data;
    else if (mem_we)    mem[widx(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[widx(mem_addr)];
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic begin_prog();
    rst_ni = 1'b0;
    @(negedge clk_i); clr = 1'b1;
    @(negedge clk_i); clr = 1'b0;
  endtask

  task automatic poke(int idx, logic [31:0] d);
    ld_en = 1'b1; ld_idx = 8'(idx); ld_data = d;
    @(negedge clk_i); ld_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        trap;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{6'h20, 32'd5,         32'd7,         32'd12,        1'b0},
    '{6'h20, 32'h7FFF_FFFF, 32'd1,         32'd0,         1'b1},
    '{6'h22, 32'd10,        32'd3,         32'd7,         1'b0},
    '{6'h22, 32'h8000_0000, 32'd1,         32'd0,         1'b1},
    '{6'h22, 32'd3,         32'd10,        32'hFFFF_FFF9, 1'b0},
    '{6'h24, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0},
    '{6'h25, 32'hF0F0_F0F0, 32'h0F00_00FF, 32'hFFF0_F0FF, 1'b0},
    '{6'h2A, 32'hFFFF_FFFF, 32'd1,         32'd1,         1'b0},
    '{6'h2A, 32'd1,         32'hFFFF_FFFF, 32'd0,         1'b0},
    '{6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1,         1'b0},
    '{6'h20, 32'hFFFF_FFFF, 32'd1,         32'd0,         1'b0}
  };

  // lw r1; lw r2; op r3,r1,r2; sw r3 -> 0x108; loop. Handler stores r3 -> 0x10C.
  task automatic load_vec_prog(vec_t v);
    begin_prog();
    poke(0, enc_i(6'h23, 0, 1, 16'h0100));
    poke(1, enc_i(6'h23, 0, 2, 16'h0104));
    poke(2, enc_r(1, 2, 3, v.fn));
    poke(3, enc_i(6'h2B, 0, 3, 16'h0108));
    poke(4, enc_j(26'd4));
    poke(64, v.a);
    poke(65, v.b);
    poke(66, 32'hA5A5_A5A5);
    poke(67, 32'h5A5A_5A5A);
    poke(128, enc_i(6'h2B, 0, 3, 16'h010C));
    poke(129, enc_j(26'd1));
  endtask

  initial begin
    // R1: reset state
    begin_prog();
    poke(0, enc_r(0, 0, 3, 6'h20));
    chk("R1 pc in reset", pc, 32'h0);
    chk("R1 epc in reset", epc, 32'h0);
    chk("R1 cause in reset", cause, 32'h0);
    chk("R1 no write in reset", {31'd0, mem_we}, 32'h0);
    go();
    edges(1);
    chk("R1 R2 first fetch at 0", pc, 32'd4);

    // R4 R9: vector table
    for (int v = 0; v < NV; v++) begin
      load_vec_prog(VECS[v]);
      go();
      if (VECS[v].trap) begin
        edges(14);
        chk("R9 pc before trap", pc, 32'd12);
        edges(1);
        chk("R9 pc at vector", pc, 32'hC000_0000);
        edges(25);
        chk("R9 rd unwritten", mem[67], 32'h0);
        chk("R9 result not stored", mem[66], 32'hA5A5_A5A5);
        chk("R9 epc", epc, 32'd8);
        chk("R9 cause", cause, 32'd1);
      end else begin
        edges(40);
        chk("R4 result", mem[66], VECS[v].res);
        chk("R11 no handler entry", mem[67], 32'h5A5A_5A5A);
        chk("R11 epc untouched", epc, 32'h0);
        chk("R11 cause untouched", cause, 32'h0);
      end
    end

    // R2 R3 R5 R7: load timing, low address bits, store timing, jump
    begin_prog();
    poke(0, enc_i(6'h23, 0, 1, 16'h0102));
    poke(1, enc_i(6'h2B, 0, 1, 16'h0108));
    poke(2, enc_j(26'd2));
    poke(64, 32'hDEAD_BEEF);
    go();
    edges(5);
    chk("R3 load still 5 cycles", pc, 32'd4);
    edges(1);
    chk("R3 next fetch after load", pc, 32'd8);
    edges(3);
    chk("R5 R2 stored loaded word", mem[66], 32'hDEAD_BEEF);
    edges(1);
    chk("R3 store 4 cycles", pc, 32'd12);
    edges(2);
    chk("R7 jump target", pc, 32'd8);

    // R8: register 0 ignores writes
    begin_prog();
    poke(0, enc_i(6'h23, 0, 1, 16'h0100));
    poke(1, enc_r(1, 1, 0, 6'h20));
    poke(2, enc_i(6'h2B, 0, 0, 16'h0108));
    poke(3, enc_j(26'd3));
    poke(64, 32'd5);
    poke(66, 32'h55);
    go();
    edges(13);
    chk("R8 r0 stays zero", mem[66], 32'h0);

    // R6: branch taken
    begin_prog();
    poke(0, enc_i(6'h04, 0, 0, 16'd3));
    go();
    edges(3);
    chk("R6 R3 taken target", pc, 32'd16);
    edges(1);
    chk("R6 fetch at target", pc, 32'd20);

    // R6: branch not taken
    begin_prog();
    poke(0, enc_i(6'h23, 0, 1, 16'h0100));
    poke(1, enc_i(6'h04, 1, 0, 16'd3));
    poke(64, 32'd1);
    go();
    edges(8);
    chk("R6 not taken holds", pc, 32'd8);
    edges(1);
    chk("R6 falls through", pc, 32'd12);

    // R10: undefined opcode
    begin_prog();
    poke(0, 32'hFC00_0000);
    go();
    edges(3);
    chk("R10 opcode trap pc", pc, 32'hC000_0000);
    chk("R10 opcode cause", cause, 32'h0);

    // R10: undefined function code, after one good instruction
    begin_prog();
    poke(0, enc_r(0, 0, 3, 6'h20));
    poke(1, enc_r(0, 0, 3, 6'h3F));
    go();
    edges(6);
    chk("R10 pc before trap", pc, 32'd8);
    edges(1);
    chk("R10 funct trap pc", pc, 32'hC000_0000);
    chk("R10 funct epc", epc, 32'd4);
    chk("R10 funct cause", cause, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule